// File: doc/BRIEF.md
# I2C SCL timing generator

This unit produces the clock line waveform for an I2C master together with the strobes the bit engine needs to place data and START/STOP conditions. All timing is counted in units of a prescaled functional clock. The prescaler divides by a power of two. Four programmable counts set the timing: the low phase, the high phase, a setup/hold delay for START/STOP and a data-valid delay. The generator also watches the real level of the clock line. It starts counting the high phase only once that level has been seen high through a small synchronizer. A target that holds the line low therefore stretches the period, and the synchronizer adds a fixed latency to every period.

The enable input gates the whole unit. While it is low the line is released and no events are produced. The configuration inputs are expected to be changed only while the enable is low. The choice of divider and counts is left to software.

Top module: `i2c_scl_timer`

## Requirements
- R1: While rst_n is low at a clock edge, and afterwards until the enable is first seen high, scl_o is 1 (line released) and scl_rise_o, scl_fall_o, sethold_o and data_valid_o are all 0.
- R2: When enable_i is sampled low, in the next cycle scl_o is 1 and no event output is high, and a pending data-valid or setup/hold strobe is cancelled. When enable_i is sampled high while the unit is idle, in the next cycle scl_o is 0 and scl_fall_o is 1.
- R3: A prescaler field value P (3 bits, 0 to 7) makes each count unit last 2^P functional clock cycles, so the divisor runs from 1 to 128.
- R4: scl_o stays low for exactly (cfg_low_i+1)*2^P cycles. scl_fall_o is a one-cycle pulse in the first low cycle.
- R5: scl_rise_o is a one-cycle pulse in the first cycle scl_o is high. The high count starts only after scl_in_i has been seen high through SYNC_STAGES synchronizer flops. When scl_in_i follows scl_o, the high width is (cfg_high_i+1)*2^P + SYNC_STAGES + 1 cycles.
- R6: With the default SYNC_STAGES of 1 and scl_in_i following scl_o, the period is (cfg_high_i+cfg_low_i+2)*2^P + 2 cycles. scl_rise_o and scl_fall_o are never high together.
- R7: If scl_in_i is held low for k cycles counted from the scl_rise_o cycle, the high width grows by exactly k. No fall occurs while the line is observed low after the release.
- R8: data_valid_o pulses for one cycle cfg_dv_i*2^P cycles after the scl_fall_o cycle, and in that same cycle when cfg_dv_i is 0. Each fall restarts this timer, so it fires at most once per fall and not at all if the next fall comes first.
- R9: sethold_o pulses for one cycle cfg_sh_i*2^P cycles after the first counted high cycle, which is SYNC_STAGES+1 cycles after scl_rise_o when the line follows. Each start of a high count restarts this timer, and the pulse may land after the following fall.
- R10: With P=0, high count 1, low count 3, setup/hold 2 and data-valid 1, the line is low for 4 cycles and high for 4 cycles, giving an 8-cycle period. sethold_o fires in the first cycle of the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Master enable; low releases the line and stops all timing |
| cfg_presc_i | input | PRE_W (3) | Prescaler exponent P, divisor 2^P |
| cfg_high_i | input | CNT_W (6) | High phase count |
| cfg_low_i | input | CNT_W (6) | Low phase count |
| cfg_sh_i | input | CNT_W (6) | START/STOP setup/hold delay count |
| cfg_dv_i | input | CNT_W (6) | Data-valid delay count after a fall |
| scl_in_i | input | 1 | Observed level of the clock line |
| scl_o | output | 1 | Clock line drive: 0 pulls low, 1 releases |
| scl_rise_o | output | 1 | One-cycle pulse when the line is released |
| scl_fall_o | output | 1 | One-cycle pulse when the line is pulled low |
| sethold_o | output | 1 | Setup/hold complete strobe |
| data_valid_o | output | 1 | Data-valid strobe |

## Verification
scl_o, scl_rise_o and scl_fall_o are registered, so each changes one cycle after the edge at which a phase end, an enable or an observed high level is sampled. The two strobes are decoded from their timer state and are due exactly count*2^P cycles after the edge pulse that started them. The bench model advances its own integer counters on each rising edge from the same inputs and compares every output at the following falling edge. It adds explicit width and strobe-position checks that sample at the cycle counts given in the requirements.

// File: rtl/i2c_scl_pkg.sv
// Shared types for the SCL timing generator.
// Assumes nothing beyond a single clock domain.
package i2c_scl_pkg;

    // Phase of the clock line generator.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // disabled, line released
        PH_LOW  = 2'd1,  // line driven low, counting low phase
        PH_WAIT = 2'd2,  // line released, waiting to observe high
        PH_HIGH = 2'd3   // line observed high, counting high phase
    } scl_phase_e;

endpackage

// File: rtl/i2c_scl_sync.sv
// Level synchronizer for the observed clock line.
// A chain of STAGES flops; resets to 1 because an idle bus is high.
// Assumes STAGES >= 1. Latency is STAGES cycles.
module i2c_scl_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One synchronizer flop; stage 0 takes the raw line level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b1;
                end else begin
                    chain_q[g] <= (g == 0) ? d_i : chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_scl_div.sv
// Power-of-two prescaler. Counts functional cycles modulo 2^sel and
// flags the last cycle of each prescaled unit (tick) and the first (zero).
// A clear restarts the unit so that the next cycle is its first.
// Assumes sel_i is held stable while the divider is running.
module i2c_scl_div #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] sel_i,
    output logic             tick_o,
    output logic             zero_o
);

    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] mask;

    // Terminal count of the unit: 2^sel - 1, wrapping to all ones at the top.
    always_comb begin
        mask = DIV_W'((DIV_W+1)'(1) << sel_i) - DIV_W'(1);
    end

    assign tick_o = (cnt_q == mask);
    assign zero_o = (cnt_q == '0);

    // Cycle counter inside one prescaled unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/i2c_scl_evt.sv
// One-shot delay timer in prescaled units. A start arms it with a zero
// count; it fires for one cycle when target*2^sel cycles have passed
// since arming (in the arming cycle itself when target is 0), then disarms.
// A new start while armed restarts it. Dropping the enable cancels it.
module i2c_scl_evt #(
    parameter int PRE_W = 3,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic [PRE_W-1:0] sel_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             fire_o
);

    logic             armed_q;
    logic [CNT_W-1:0] unit_q;
    logic             div_tick;
    logic             div_zero;
    logic             div_clr;

    assign div_clr = start_i || !armed_q;

    i2c_scl_div #(.PRE_W(PRE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (div_clr),
        .sel_i  (sel_i),
        .tick_o (div_tick),
        .zero_o (div_zero)
    );

    assign fire_o = armed_q && div_zero && (unit_q == target_i);

    // Arm, count prescaled units, and disarm after firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            unit_q  <= '0;
        end else if (!en_i) begin
            armed_q <= 1'b0;
            unit_q  <= '0;
        end else if (start_i) begin
            armed_q <= 1'b1;
            unit_q  <= '0;
        end else if (fire_o) begin
            armed_q <= 1'b0;
        end else if (armed_q && div_tick) begin
            unit_q <= unit_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/i2c_scl_timer.sv
// SCL timing generator for an I2C master.
// Drives the line low for (low+1) prescaled units, releases it, waits
// until the synchronized line level is high, then counts (high+1) units
// before pulling low again. Rise/fall pulses mark the drive changes; two
// one-shot timers give the setup/hold and data-valid strobes.
// Assumes the configuration inputs only change while enable_i is low.
module i2c_scl_timer #(
    parameter int PRE_W       = 3,
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [PRE_W-1:0] cfg_presc_i,
    input  logic [CNT_W-1:0] cfg_high_i,
    input  logic [CNT_W-1:0] cfg_low_i,
    input  logic [CNT_W-1:0] cfg_sh_i,
    input  logic [CNT_W-1:0] cfg_dv_i,
    input  logic             scl_in_i,
    output logic             scl_o,
    output logic             scl_rise_o,
    output logic             scl_fall_o,
    output logic             sethold_o,
    output logic             data_valid_o
);

    import i2c_scl_pkg::*;

    scl_phase_e       phase_q;
    logic [CNT_W-1:0] unit_q;
    logic             obs_hi;
    logic             ph_tick;
    logic             ph_zero;
    logic             ph_clr;
    logic             go_low;
    logic             go_wait;
    logic             go_high;
    logic             drive_q;
    logic             rise_q;
    logic             fall_q;

    i2c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (scl_in_i),
        .q_o   (obs_hi)
    );

    i2c_scl_div #(.PRE_W(PRE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ph_clr),
        .sel_i  (cfg_presc_i),
        .tick_o (ph_tick),
        .zero_o (ph_zero)
    );

    // Phase transition decode from the current phase and unit count.
    always_comb begin
        go_low  = enable_i && ((phase_q == PH_IDLE) ||
                  (phase_q == PH_HIGH && ph_tick && unit_q == cfg_high_i));
        go_wait = enable_i && (phase_q == PH_LOW) && ph_tick && (unit_q == cfg_low_i);
        go_high = enable_i && (phase_q == PH_WAIT) && obs_hi;
        ph_clr  = !enable_i || go_low || go_wait || go_high ||
                  (phase_q == PH_IDLE) || (phase_q == PH_WAIT);
    end

    // Phase register, line drive and edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            phase_q <= PH_IDLE;
            drive_q <= 1'b1;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            rise_q <= go_wait;
            fall_q <= go_low;
            if (go_low) begin
                phase_q <= PH_LOW;
                drive_q <= 1'b0;
            end else if (go_wait) begin
                phase_q <= PH_WAIT;
                drive_q <= 1'b1;
            end else if (go_high) begin
                phase_q <= PH_HIGH;
            end
        end
    end

    // Prescaled unit count within the low or high phase.
    always_ff @(posedge clk) begin
        if (!rst_n || ph_clr) begin
            unit_q <= '0;
        end else if (ph_tick) begin
            unit_q <= unit_q + CNT_W'(1);
        end
    end

    // Data-valid delay, started at every fall.
    i2c_scl_evt #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dv (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable_i),
        .start_i  (go_low),
        .sel_i    (cfg_presc_i),
        .target_i (cfg_dv_i),
        .fire_o   (data_valid_o)
    );

    // Setup/hold delay, started when the high count begins.
    i2c_scl_evt #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable_i),
        .start_i  (go_high),
        .sel_i    (cfg_presc_i),
        .target_i (cfg_sh_i),
        .fire_o   (sethold_o)
    );

    assign scl_o      = drive_q;
    assign scl_rise_o = rise_q;
    assign scl_fall_o = fall_q;

    logic unused_zero;
    assign unused_zero = ph_zero;

endmodule

// File: rtl/i2c_scl_timer_chk.sv
// Property checker for the SCL timing generator, bound to the top.
// Observes ports plus the phase register and synchronized line level.
module i2c_scl_timer_chk
    import i2c_scl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic       scl_o,
    input logic       scl_rise_o,
    input logic       scl_fall_o,
    input logic       sethold_o,
    input logic       data_valid_o,
    input logic [5:0] cfg_dv_i,
    input scl_phase_e phase_q,
    input logic       obs_hi
);

    // R2: a low enable leaves the line released and quiet next cycle.
    assert_disable_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (scl_o && !scl_rise_o && !scl_fall_o && !sethold_o && !data_valid_o));

    // R4: the fall pulse coincides with a low drive.
    assert_fall_drives_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_o |-> !scl_o);

    // R5: the rise pulse marks a real low-to-high drive change.
    assert_rise_is_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_o |-> (scl_o && !$past(scl_o)));

    // R6: rise and fall never coincide.
    assert_edges_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise_o, scl_fall_o}));

    // R7: while waiting with the line seen low, the drive stays released.
    assert_stretch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && phase_q == PH_WAIT && !obs_hi) |=> (scl_o && !scl_fall_o));

    // R8: a zero data-valid delay fires with the fall.
    assert_dv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall_o && cfg_dv_i == 6'd0) |-> data_valid_o);

endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .scl_o        (scl_o),
    .scl_rise_o   (scl_rise_o),
    .scl_fall_o   (scl_fall_o),
    .sethold_o    (sethold_o),
    .data_valid_o (data_valid_o),
    .cfg_dv_i     (cfg_dv_i),
    .phase_q      (phase_q),
    .obs_hi       (obs_hi)
);

// File: tb/i2c_scl_timer_tb.sv
// Bench for the SCL timing generator: a behavioural cycle model compared
// at every falling edge, plus explicit width and strobe checks.
module i2c_scl_timer_tb;

    localparam int SYNC = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] presc = 3'd0;
    logic [5:0] c_hi = 6'd1, c_lo = 6'd3, c_sh = 6'd2, c_dv = 6'd1;
    logic       hold = 1'b0;
    logic       scl_in;
    logic       scl_o, scl_rise_o, scl_fall_o, sethold_o, data_valid_o;

    int  n_chk = 0;
    int  n_err = 0;
    int  cyc = 0;
    bit  chk_on = 1'b0;

    always #5 clk = ~clk;

    assign scl_in = scl_o & ~hold;

    i2c_scl_timer #(.SYNC_STAGES(SYNC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (en),
        .cfg_presc_i  (presc),
        .cfg_high_i   (c_hi),
        .cfg_low_i    (c_lo),
        .cfg_sh_i     (c_sh),
        .cfg_dv_i     (c_dv),
        .scl_in_i     (scl_in),
        .scl_o        (scl_o),
        .scl_rise_o   (scl_rise_o),
        .scl_fall_o   (scl_fall_o),
        .sethold_o    (sethold_o),
        .data_valid_o (data_valid_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    int m_st = 0;   // 0 idle, 1 low, 2 waiting for high, 3 high
    int m_cnt = 0;
    bit m_scl = 1'b1, m_fall = 1'b0, m_rise = 1'b0;
    bit m_dv_arm = 1'b0, m_sh_arm = 1'b0;
    int m_dv_cnt = 0, m_sh_cnt = 0;
    bit m_sq [SYNC];

    function automatic int units(input logic [5:0] n);
        return int'(n) << int'(presc);
    endfunction

    always @(posedge clk) begin : model
        bit sin, shi, gl, gw, gh, dvf, shf;
        sin = m_scl & ~hold;
        shi = m_sq[SYNC-1];
        if (!rst_n || !en) begin
            m_st = 0; m_cnt = 0; m_scl = 1'b1; m_fall = 1'b0; m_rise = 1'b0;
            m_dv_arm = 1'b0; m_sh_arm = 1'b0; m_dv_cnt = 0; m_sh_cnt = 0;
        end else begin
            gl  = (m_st == 0) || (m_st == 3 && m_cnt == units(c_hi) + units(6'd1) - 1);
            gw  = (m_st == 1 && m_cnt == units(c_lo) + units(6'd1) - 1);
            gh  = (m_st == 2 && shi);
            dvf = m_dv_arm && (m_dv_cnt == units(c_dv));
            shf = m_sh_arm && (m_sh_cnt == units(c_sh));
            m_fall = gl;
            m_rise = gw;
            if (gl) begin m_st = 1; m_cnt = 0; m_scl = 1'b0; end
            else if (gw) begin m_st = 2; m_cnt = 0; m_scl = 1'b1; end
            else if (gh) begin m_st = 3; m_cnt = 0; end
            else if (m_st == 1 || m_st == 3) m_cnt++;
            if (gl) begin m_dv_arm = 1'b1; m_dv_cnt = 0; end
            else if (dvf) m_dv_arm = 1'b0;
            else if (m_dv_arm) m_dv_cnt++;
            if (gh) begin m_sh_arm = 1'b1; m_sh_cnt = 0; end
            else if (shf) m_sh_arm = 1'b0;
            else if (m_sh_arm) m_sh_cnt++;
        end
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) m_sq[i] = 1'b1;
        end else begin
            for (int i = SYNC-1; i > 0; i--) m_sq[i] = m_sq[i-1];
            m_sq[0] = sin;
        end
        chk_on = 1'b1;
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_on) begin
            chk(scl_o == m_scl, "R6 scl_o vs model", int'(scl_o), int'(m_scl));
            chk(scl_fall_o == m_fall, "R4 scl_fall_o vs model", int'(scl_fall_o), int'(m_fall));
            chk(scl_rise_o == m_rise, "R5 scl_rise_o vs model", int'(scl_rise_o), int'(m_rise));
            chk(data_valid_o == (m_dv_arm && m_dv_cnt == units(c_dv)), "R8 data_valid_o vs model",
                int'(data_valid_o), int'(m_dv_arm && m_dv_cnt == units(c_dv)));
            chk(sethold_o == (m_sh_arm && m_sh_cnt == units(c_sh)), "R9 sethold_o vs model",
                int'(sethold_o), int'(m_sh_arm && m_sh_cnt == units(c_sh)));
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    // From a fall cycle, count low then high cycles; returns at the next fall.
    task automatic meas(output int lw, output int hw);
        while (!scl_fall_o) @(negedge clk);
        lw = 0;
        while (!scl_o) begin lw++; @(negedge clk); end
        hw = 0;
        while (scl_o) begin hw++; @(negedge clk); end
    endtask

    task automatic set_cfg(input int p, input int hi, input int lo, input int sh, input int dv);
        en = 1'b0;
        repeat (2) @(negedge clk);
        presc = 3'(p); c_hi = 6'(hi); c_lo = 6'(lo); c_sh = 6'(sh); c_dv = 6'(dv);
        @(negedge clk);
    endtask

    task automatic run_cfg(input int p, input int hi, input int lo, input int sh, input int dv,
                           input string tag);
        int l1, h1, l2, h2;
        set_cfg(p, hi, lo, sh, dv);
        en = 1'b1;
        @(negedge clk);
        meas(l1, h1);
        meas(l2, h2);
        chk(l1 == ((lo+1) << p), {tag, " R4 low width"}, l1, (lo+1) << p);
        chk(h1 == ((hi+1) << p) + SYNC + 1, {tag, " R5 high width"}, h1, ((hi+1) << p) + SYNC + 1);
        chk(l2 + h2 == ((hi+lo+2) << p) + 2, {tag, " R6 period"}, l2 + h2, ((hi+lo+2) << p) + 2);
        chk(l2 == (1 << p) * (lo+1), {tag, " R3 prescaled unit"}, l2, (1 << p) * (lo+1));
        en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int hw;
        // R1: reset state.
        repeat (4) @(negedge clk);
        chk(scl_o == 1'b1, "R1 scl_o in reset", int'(scl_o), 1);
        chk({scl_rise_o, scl_fall_o, sethold_o, data_valid_o} == 4'b0, "R1 events in reset",
            int'({scl_rise_o, scl_fall_o, sethold_o, data_valid_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl_o == 1'b1, "R1 scl_o idle before enable", int'(scl_o), 1);

        // R10: fastest setting; then several prescale/count settings (R3..R6).
        run_cfg(0, 1, 3, 2, 1, "R10");
        run_cfg(3, 5, 10, 5, 5, "cfgB");
        run_cfg(7, 2, 4, 2, 2, "cfgC");
        run_cfg(1, 31, 62, 31, 15, "cfgD");

        // R8/R9: zero delays fire at the fall and at the first counted high cycle.
        set_cfg(2, 3, 6, 0, 0);
        en = 1'b1;
        @(negedge clk);
        chk(scl_fall_o == 1'b1, "R2 fall one cycle after enable", int'(scl_fall_o), 1);
        chk(data_valid_o == 1'b1, "R8 zero delay with fall", int'(data_valid_o), 1);
        while (!scl_rise_o) @(negedge clk);
        repeat (SYNC + 1) @(negedge clk);
        chk(sethold_o == 1'b1, "R9 zero delay at high start", int'(sethold_o), 1);

        // R7: stretch by holding the line low 7 cycles after release.
        set_cfg(0, 4, 4, 2, 1);
        hold = 1'b1;
        en = 1'b1;
        @(negedge clk);
        while (!scl_rise_o) @(negedge clk);
        hw = 0;
        for (int i = 0; i < 7; i++) begin hw++; @(negedge clk); end
        hold = 1'b0;
        while (scl_o) begin hw++; @(negedge clk); end
        chk(hw == 7 + SYNC + 1 + 5, "R7 stretched high width", hw, 7 + SYNC + 1 + 5);

        // R2: disable mid-low cancels the pending data-valid strobe.
        set_cfg(0, 4, 20, 2, 10);
        en = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b1, "R2 released after disable", int'(scl_o), 1);
        for (int i = 0; i < 20; i++) begin
            chk(data_valid_o == 1'b0, "R2 no strobe while disabled", int'(data_valid_o), 0);
            @(negedge clk);
        end
        en = 1'b1;
        @(negedge clk);
        chk(scl_fall_o == 1'b1 && scl_o == 1'b0, "R2 fall after re-enable", int'(scl_fall_o), 1);
        repeat (60) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end

endmodule